// File: doc/BRIEF.md
# Write-Back Line Cache Controller with Fixed-Timing Burst Port

This block is a direct-mapped write-back cache controller between a processor request port and a main-memory burst port. The processor issues one 64-bit read or write at a time. The controller looks up a tag array. On a hit it serves the request from its own data array. On a miss it moves whole 32-byte lines over the memory port. Each line moves as four 64-bit beats, and the first beat costs three clocks while each later beat costs one.

The request side is valid/ready. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` then stays low until the response has been given, so only one request is ever outstanding. The requester holds its request stable while `req_ready` is low. The response is a one-cycle `rsp_valid` pulse with no back-pressure, so the requester must take it in that cycle. The memory side has no handshake. The memory must complete a beat in every cycle where `mem_strobe` is high. On a read beat it presents the addressed word on `mem_rdata` in that same cycle. On a write beat it stores `mem_wdata` in that cycle.

Top module: `line_cache_ctrl`

## Requirements
- R1: A byte address splits into a 5-bit line offset, an index of log2(LINES) bits above it, and a tag made of the remaining upper bits. Bits [4:3] select the 64-bit word within the line. Each index has exactly one line slot.
- R2: A read hit raises `rsp_valid` for exactly one cycle, one clock edge after the accepting edge. `rsp_rdata` then carries the addressed word.
- R3: A write hit changes only the bytes of the addressed word whose `req_be` bit is set (bit n covers data bits 8n+7..8n). It marks the line dirty and responds one edge after acceptance.
- R4: A miss on an invalid or clean slot causes exactly one read burst. The beats use line base + 8·k for k = 0,1,2,3, in that order. The response comes 8 edges after acceptance, only once the whole line is in.
- R5: A miss on a dirty slot first writes the old line back to its own address as a four-beat burst, then fills the new line. The response comes 14 edges after acceptance.
- R6: Every burst takes six cycles with `mem_cyc` high. `mem_strobe` is low in the first two cycles and high in cycles 3, 4, 5 and 6 (3-1-1-1).
- R7: `req_ready` is low from the accepting edge until the response cycle has ended, and it is low during every burst cycle.
- R8: Reset clears every valid and dirty bit. After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_cyc` is 0. A slot that was dirty before reset is refilled afterwards without any write-back.
- R9: A write miss allocates. It fills the line first, then merges the write under its byte enables, so later reads see both the fetched bytes and the written bytes.
- R10: LINES is a power of two from 2 to 8192, giving up to 256 KB of line storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the 64-bit word |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for writes |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read data, meaningful for reads |
| mem_cyc | output | 1 | A burst is in progress |
| mem_we | output | 1 | 1 = write-back burst, 0 = fill burst |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_strobe | output | 1 | A beat completes in this cycle |
| mem_wdata | output | 64 | Beat data for write-back |
| mem_rdata | input | 64 | Beat data for fill |

## Verification
The bench runs a fixed sequence of reads and writes over a behavioural memory, with eight lines. The sequence covers a cold miss, a read hit and a write hit. It also covers a miss that evicts a dirty line, a miss that evicts a clean line, and write misses with partial byte enables. The measured latency tells the three cases apart: 1 edge for a hit, 8 for a single fill, and 14 for a write-back followed by a fill. Read data that is checked against a shadow copy shows that a dirty line really reached memory and that partial writes merged with fetched bytes. A monitor checks the position of every strobe within its burst, the beat order and `req_ready`. A reset taken while a slot is dirty must lead to a plain 8-edge fill.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  localparam int WORD_W      = 64;
  localparam int BE_W        = WORD_W / 8;
  localparam int LINE_BYTES  = 32;
  localparam int OFF_W       = $clog2(LINE_BYTES);
  localparam int BEATS       = LINE_BYTES / BE_W;
  localparam int BEAT_W      = $clog2(BEATS);
  localparam int FIRST_CLKS  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_WB,
    ST_FILL,
    ST_RESP
  } lcc_state_e;
endpackage

// File: rtl/lcc_burst_seq.sv
module lcc_burst_seq
  import lcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              strobe,
  output logic              done,
  output logic [BEAT_W-1:0] beat
);
  localparam int WAIT_W = $clog2(FIRST_CLKS);

  logic [WAIT_W-1:0] wait_q;
  logic              busy_q;
  logic [BEAT_W-1:0] beat_q;

  assign busy   = busy_q;
  assign beat   = beat_q;
  // first beat pays addressing and precharge; later beats complete each clock
  assign strobe = busy_q && ((beat_q != '0) || (wait_q == WAIT_W'(FIRST_CLKS - 1)));
  assign done   = strobe && (beat_q == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      wait_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      beat_q <= '0;
      wait_q <= '0;
    end else if (busy_q) begin
      if (strobe) begin
        if (done) busy_q <= 1'b0;
        else      beat_q <= beat_q + 1'b1;
      end else begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end

  // R6: two idle clocks, then the first beat completes
  p_first_beat_cost_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> !strobe ##1 !strobe ##1 strobe);
  // R6: once beats start they complete back to back
  p_beats_back_to_back_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe && !done && !start) |=> strobe);
endmodule

// File: rtl/lcc_tag_store.sv
module lcc_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             install,
  input  logic [TAG_W-1:0] install_tag,
  input  logic             set_dirty,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (install) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (set_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) tag_q[idx] <= install_tag;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    // R3: a line can only become dirty after it was installed
    p_dirty_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
      dirty_q[i] |-> valid_q[i]);
  end
endmodule

// File: rtl/lcc_data_store.sv
module lcc_data_store
  import lcc_pkg::*;
#(
  parameter int LINES = 8,
  localparam int WIDX_W = $clog2(LINES) + BEAT_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] words_q [LINES*BEATS];

  assign rd_data = words_q[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be[b]) words_q[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/line_cache_ctrl.sv
module line_cache_ctrl
  import lcc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_cyc,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_strobe,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WIDX_W = IDX_W + BEAT_W;

  lcc_state_e        state_q;
  logic [ADDR_W-1:3] addr_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic [WORD_W-1:0] rdata_q;

  wire unused_lowbits = ^req_addr[2:0];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [BEAT_W-1:0] word;
  assign idx  = addr_q[OFF_W+IDX_W-1:OFF_W];
  assign tag  = addr_q[ADDR_W-1:OFF_W+IDX_W];
  assign word = addr_q[OFF_W-1:3];

  logic             t_valid, t_dirty;
  logic [TAG_W-1:0] t_tag;
  logic             hit;
  assign hit = t_valid && (t_tag == tag);

  logic              seq_start, seq_busy, seq_strobe, seq_done;
  logic [BEAT_W-1:0] beat;
  assign seq_start = ((state_q == ST_CMP) && !hit) || ((state_q == ST_WB) && seq_done);

  lcc_burst_seq u_seq (
    .clk(clk), .rst(rst), .start(seq_start), .busy(seq_busy),
    .strobe(seq_strobe), .done(seq_done), .beat(beat)
  );

  logic install, set_dirty;
  assign install   = (state_q == ST_FILL) && seq_done;
  assign set_dirty = (state_q == ST_CMP) && hit && we_q;

  lcc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(idx), .install(install), .install_tag(tag),
    .set_dirty(set_dirty), .rd_valid(t_valid), .rd_dirty(t_dirty), .rd_tag(t_tag)
  );

  logic              d_wr_en;
  logic [WIDX_W-1:0] d_wr_idx, d_rd_idx;
  logic [WORD_W-1:0] d_wr_data, d_rd_data;
  logic [BE_W-1:0]   d_wr_be;

  always_comb begin
    if (state_q == ST_FILL) begin
      d_wr_en   = seq_strobe;
      d_wr_idx  = {idx, beat};
      d_wr_data = mem_rdata;
      d_wr_be   = '1;
    end else begin
      d_wr_en   = set_dirty;
      d_wr_idx  = {idx, word};
      d_wr_data = wdata_q;
      d_wr_be   = be_q;
    end
  end
  assign d_rd_idx = (state_q == ST_WB) ? {idx, beat} : {idx, word};

  lcc_data_store #(.LINES(LINES)) u_data (
    .clk(clk), .wr_en(d_wr_en), .wr_idx(d_wr_idx), .wr_data(d_wr_data),
    .wr_be(d_wr_be), .rd_idx(d_rd_idx), .rd_data(d_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) state_q <= ST_CMP;
        ST_CMP: begin
          if (hit)                   state_q <= ST_RESP;
          else if (t_valid && t_dirty) state_q <= ST_WB;
          else                       state_q <= ST_FILL;
        end
        ST_WB:   if (seq_done) state_q <= ST_FILL;
        ST_FILL: if (seq_done) state_q <= ST_CMP;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if ((state_q == ST_IDLE) && req_valid) begin
      addr_q  <= req_addr[ADDR_W-1:3];
      we_q    <= req_we;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
    if ((state_q == ST_CMP) && hit && !we_q) rdata_q <= d_rd_data;
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_rdata  = rdata_q;
  assign mem_cyc    = seq_busy;
  assign mem_we     = (state_q == ST_WB);
  assign mem_strobe = seq_strobe;
  assign mem_wdata  = d_rd_data;
  assign mem_addr   = {(state_q == ST_WB) ? t_tag : tag, idx, beat, 3'b000};

  // R7: no request is taken while a burst runs
  p_no_accept_in_burst_r7: assert property (@(posedge clk) disable iff (rst)
    mem_cyc |-> !req_ready);
  // R7: an accepted request closes the port on the next cycle
  p_accept_closes_port_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R2: the response is a single-cycle pulse
  p_rsp_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R5: the write-back burst is followed directly by the fill burst
  p_writeback_then_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_cyc && mem_we && mem_strobe && (mem_addr[4:3] == 2'd3)) |=> (mem_cyc && !mem_we));
endmodule

// File: tb/line_cache_ctrl_test.sv
`timescale 1ns/1ps
module line_cache_ctrl_test;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        req_ready, rsp_valid, mem_cyc, mem_we, mem_strobe;
  logic [63:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  line_cache_ctrl #(.ADDR_W(AW), .LINES(8)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_cyc(mem_cyc), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_strobe(mem_strobe), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // behavioural memory (2 KB) and shadow of what the processor should read
  logic [63:0] bmem [256];
  logic [63:0] gold [256];
  assign mem_rdata = bmem[mem_addr[10:3]];

  int checks = 0, errors = 0;
  int mchecks = 0, merrors = 0;
  int pos = 0, nbeat = 0;

  // memory-side monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (mem_cyc) begin
      pos = pos + 1;
      if (mem_strobe) begin
        mchecks = mchecks + 1;
        if (pos != ((nbeat == 0) ? 3 : 3 + nbeat) || mem_addr[4:3] != nbeat[1:0]) begin
          merrors = merrors + 1;
          $display("FAIL R6/R4 beat timing: cycle=%0d beat_addr=%0d expected cycle=%0d beat=%0d",
                   pos, mem_addr[4:3], (nbeat == 0) ? 3 : 3 + nbeat, nbeat);
        end
        mchecks = mchecks + 1;
        if (req_ready) begin
          merrors = merrors + 1;
          $display("FAIL R7 ready during burst: actual=1 expected=0");
        end
        if (mem_we) bmem[mem_addr[10:3]] = mem_wdata;
        if (nbeat == 3) begin nbeat = 0; pos = 0; end
        else nbeat = nbeat + 1;
      end
    end
  end

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [7:0]  be;
    logic [63:0] wd;
    logic [4:0]  lat;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{1'b0, 12'h000, 8'h00, 64'h0, 5'd8},                    // R4 cold fill
    '{1'b0, 12'h008, 8'h00, 64'h0, 5'd1},                    // R2 read hit
    '{1'b1, 12'h010, 8'hFF, 64'h1111_2222_3333_4444, 5'd1},  // R3 write hit
    '{1'b0, 12'h010, 8'h00, 64'h0, 5'd1},                    // R3 readback
    '{1'b0, 12'h100, 8'h00, 64'h0, 5'd14},                   // R5 dirty victim
    '{1'b0, 12'h010, 8'h00, 64'h0, 5'd8},                    // R5 data written back
    '{1'b1, 12'h038, 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD, 5'd8},  // R9 write miss
    '{1'b0, 12'h038, 8'h00, 64'h0, 5'd1},                    // R9 merged bytes
    '{1'b1, 12'h020, 8'hF0, 64'h9999_8888_7777_6666, 5'd1},  // R3 partial write
    '{1'b0, 12'h120, 8'h00, 64'h0, 5'd14},                   // R1 same index, new tag
    '{1'b0, 12'h020, 8'h00, 64'h0, 5'd8},                    // R5 clean victim
    '{1'b1, 12'h7E0, 8'h81, 64'hFEDC_BA98_7654_3210, 5'd8},  // R9 write miss, top slot
    '{1'b0, 12'h7E8, 8'h00, 64'h0, 5'd1},                    // R1 neighbour word hit
    '{1'b1, 12'h0E0, 8'hFF, 64'h0123_4567_89AB_CDEF, 5'd14}, // R5 write miss, dirty victim
    '{1'b0, 12'h0E0, 8'h00, 64'h0, 5'd1}                     // R2 hit after allocate
  };

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_op(input logic we, input logic [11:0] a, input logic [7:0] be,
                        input logic [63:0] wd, input int exp_lat);
    int lat;
    @(negedge clk);
    check(req_ready == 1'b1, "R7 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_we = we; req_addr = {20'd0, a}; req_be = be; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (lat < 40) begin
      @(posedge clk);
      lat = lat + 1;
      @(negedge clk);
      if (rsp_valid) break;
    end
    check(lat == exp_lat, "R2/R4/R5 latency", 64'(lat), 64'(exp_lat));
    if (we) begin
      for (int b = 0; b < 8; b++)
        if (be[b]) gold[a[10:3]][b*8 +: 8] = wd[b*8 +: 8];
    end else begin
      check(rsp_rdata == gold[a[10:3]], "R2/R3/R9 read data", rsp_rdata, gold[a[10:3]]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors + merrors, checks + mchecks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      bmem[i] = {32'hC0DE_0000 + 32'(i), 32'h5A5A_0000 ^ 32'(i)};
      gold[i] = bmem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: state after reset
    check(req_ready == 1'b1, "R8 ready after reset", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R8 no response after reset", 64'(rsp_valid), 64'd0);
    check(mem_cyc == 1'b0, "R8 memory idle after reset", 64'(mem_cyc), 64'd0);

    for (int v = 0; v < 15; v++)
      run_op(VEC[v].we, VEC[v].addr, VEC[v].be, VEC[v].wd, int'(VEC[v].lat));

    // R8: reset while slot 7 is dirty; the next miss there must not write back
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(req_ready == 1'b1 && mem_cyc == 1'b0, "R8 idle after second reset",
          64'({req_ready, mem_cyc}), 64'b10);
    run_op(1'b0, 12'h7E0, 8'h00, 64'h0, 8);   // R8 plain fill, written-back data seen

    // R10/R1: word 3 of a line, index 2, filled after reset
    run_op(1'b0, 12'h058, 8'h00, 64'h0, 8);
    run_op(1'b0, 12'h040, 8'h00, 64'h0, 1);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors + merrors, checks + mchecks);
    $finish;
  end
endmodule